// File: doc/BRIEF.md
# Segmented Paged Address Translator

This unit turns a 24-bit logical address into a physical address. The top four bits select one of sixteen segments. The next eight bits are a page index inside that segment, and the low twelve bits are the byte offset inside the page. Each segment holds two values: the physical address where its page table starts, and a limit giving how many entries that table has. These values live in a small register file. A separate load port writes them, for example when the running context changes.

A translation is accepted through a valid/ready request handshake. The unit first compares the page index against the segment limit. If the index is at or beyond the limit, the unit answers at once with a bounds fault and touches no memory. Otherwise it issues one read of the 4-byte table entry on a synchronous memory port, which returns data one cycle later. From that entry it checks the present flag and then the access permission, and it builds the physical address from the entry's frame field. The result, or a fault code, is held on the response port until it is taken. Only one translation is in flight at a time.

Top module: `seg_page_xlate`

## Requirements
- R1: For a request whose page index is below the segment limit, the unit makes exactly one memory read at address (segment table base + page index × 4). The read enable is a single-cycle pulse in the cycle after the request is accepted, and the response appears two cycles after that pulse.
- R2: A page index greater than or equal to the segment limit gives fault code 2'b01 in the cycle after acceptance, with no memory read.
- R3: An entry whose present flag (bit 2) is 0 gives fault code 2'b10, whatever its permission bits are.
- R4: A write to a present entry whose writable flag (bit 1) is 0, or a read of a present entry whose readable flag (bit 0) is 0, gives fault code 2'b11.
- R5: A translation without a fault returns fault code 2'b00 and physical address {entry bits [19:8], offset}, with the offset taken unchanged from logical bits [11:0]. A faulting response carries physical address 0.
- R6: Request ready is high only while the unit is idle. The response valid stays high with stable address and fault until response ready is seen high.
- R7: A load writes the base and limit of the selected segment only while the unit is idle. A load presented during a translation is ignored.
- R8: After reset every segment limit is 0, request ready is 1, and both response valid and the memory read enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Segment register load strobe |
| ld_seg | input | 4 | Segment to load |
| ld_base | input | 24 | Physical base of that segment's page table |
| ld_bound | input | 9 | Entry count of that segment's page table (0 to 256) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 24 | Logical address |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| mem_rd_en | output | 1 | Page-table memory read enable |
| mem_rd_addr | output | 24 | Page-table memory byte address |
| mem_rd_data | input | 32 | Entry data, valid the cycle after mem_rd_en |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 bounds, 10 not present, 11 protection |

## Verification
The assertions assume that the memory answers exactly one cycle after each read enable. They also assume that the requester drops req_valid once its request is accepted and does not raise it again until the response has been taken. The bench memory model registers a computed entry on every enabled edge. The bench drives each request for one accepted edge only and waits for the response before it issues the next. With this stimulus the timing relations between the read pulse, the acceptance and the response always hold. A sweep over every page of every segment, for both access kinds, then covers the limit comparison and all flag patterns.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_ABSENT = 2'b10,
    FLT_PROT   = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CHECK = 2'd2,
    ST_RESP  = 2'd3
  } xstate_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W   = 4,
  parameter int BASE_W  = 24,
  parameter int BOUND_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [BOUND_W-1:0] wr_bound,
  input  logic [SEG_W-1:0]   rd_idx,
  output logic [BASE_W-1:0]  rd_base,
  output logic [BOUND_W-1:0] rd_bound
);
  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0]  base_q  [NSEG];
  logic [BOUND_W-1:0] bound_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
      end else if (wr_en && wr_idx == SEG_W'(s)) begin
        base_q[s]  <= wr_base;
        bound_q[s] <= wr_bound;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_bound = bound_q[rd_idx];
endmodule

// File: rtl/pte_check.sv
module pte_check
  import xlate_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 12
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic               is_write,
  output fault_e             fault,
  output logic [FRAME_W-1:0] frame
);
  localparam int FRAME_LSB = 8;
  localparam int BIT_PRES  = 2;
  localparam int BIT_WR    = 1;
  localparam int BIT_RD    = 0;

  logic allowed;

  assign frame   = pte[FRAME_LSB +: FRAME_W];
  assign allowed = is_write ? pte[BIT_WR] : pte[BIT_RD];

  always_comb begin
    if (!pte[BIT_PRES])  fault = FLT_ABSENT;
    else if (!allowed)   fault = FLT_PROT;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  parameter int PA_W    = 24,
  parameter int BOUND_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_addr,
  input  logic                     req_write,
  output logic [SEG_W-1:0]         seg_idx,
  input  logic [PA_W-1:0]          seg_base,
  input  logic [BOUND_W-1:0]       seg_bound,
  output logic                     mem_rd_en,
  output logic [PA_W-1:0]          mem_rd_addr,
  output logic                     chk_write,
  input  fault_e                   chk_fault,
  input  logic [FRAME_W-1:0]       chk_frame,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [PA_W-1:0]          rsp_paddr,
  output fault_e                   rsp_fault,
  output logic                     idle
);
  localparam int LA_W = SEG_W + PAGE_W + OFF_W;

  xstate_e            state_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;
  logic [PA_W-1:0]    rd_addr_q;
  logic [PA_W-1:0]    paddr_q;
  fault_e             fault_q;

  logic [PAGE_W-1:0]  page;
  logic [PAGE_W+1:0]  pte_off;
  logic               out_of_bounds;

  assign seg_idx       = req_addr[LA_W-1 -: SEG_W];
  assign page          = req_addr[OFF_W +: PAGE_W];
  assign pte_off       = {page, 2'b00};
  assign out_of_bounds = BOUND_W'(page) >= seg_bound;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      off_q     <= '0;
      wr_q      <= 1'b0;
      rd_addr_q <= '0;
      paddr_q   <= '0;
      fault_q   <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            off_q <= req_addr[OFF_W-1:0];
            wr_q  <= req_write;
            if (out_of_bounds) begin
              paddr_q <= '0;
              fault_q <= FLT_BOUNDS;
              state_q <= ST_RESP;
            end else begin
              rd_addr_q <= seg_base + PA_W'(pte_off);
              state_q   <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state_q <= ST_CHECK;
        ST_CHECK: begin
          fault_q <= chk_fault;
          paddr_q <= (chk_fault == FLT_NONE) ? {chk_frame, off_q} : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle        = (state_q == ST_IDLE);
  assign req_ready   = idle;
  assign mem_rd_en   = (state_q == ST_FETCH);
  assign mem_rd_addr = rd_addr_q;
  assign chk_write   = wr_q;
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_paddr   = paddr_q;
  assign rsp_fault   = fault_q;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  parameter int PTE_W   = 32,
  parameter int PA_W    = FRAME_W + OFF_W,
  parameter int LA_W    = SEG_W + PAGE_W + OFF_W,
  parameter int BOUND_W = PAGE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [SEG_W-1:0]   ld_seg,
  input  logic [PA_W-1:0]    ld_base,
  input  logic [BOUND_W-1:0] ld_bound,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_addr,
  input  logic               req_write,
  output logic               mem_rd_en,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic [PTE_W-1:0]   mem_rd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault
);
  logic [SEG_W-1:0]   seg_idx;
  logic [PA_W-1:0]    seg_base;
  logic [BOUND_W-1:0] seg_bound;
  logic               idle;
  logic               chk_write;
  fault_e             chk_fault;
  fault_e             fault_out;
  logic [FRAME_W-1:0] chk_frame;

  seg_regfile #(.SEG_W(SEG_W), .BASE_W(PA_W), .BOUND_W(BOUND_W)) u_segs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ld_en && idle),
    .wr_idx   (ld_seg),
    .wr_base  (ld_base),
    .wr_bound (ld_bound),
    .rd_idx   (seg_idx),
    .rd_base  (seg_base),
    .rd_bound (seg_bound)
  );

  pte_check #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_chk_pte (
    .pte      (mem_rd_data),
    .is_write (chk_write),
    .fault    (chk_fault),
    .frame    (chk_frame)
  );

  xlate_ctrl #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .FRAME_W(FRAME_W), .PA_W(PA_W), .BOUND_W(BOUND_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .seg_idx     (seg_idx),
    .seg_base    (seg_base),
    .seg_bound   (seg_bound),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .chk_write   (chk_write),
    .chk_fault   (chk_fault),
    .chk_frame   (chk_frame),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (fault_out),
    .idle        (idle)
  );

  assign rsp_fault = fault_out;
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_en,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R1

  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> $past(req_valid && req_ready)); // R1

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_fault != 2'b01) |-> $past(mem_rd_en, 2)); // R1

  AST_BOUNDS_NO_READ: assert property (@(posedge clk) disable iff (rst)
    ($rose(rsp_valid) && rsp_fault == 2'b01) |-> ($past(req_valid && req_ready) && !$past(mem_rd_en))); // R2

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_rd_en) |-> !req_ready); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R6
endmodule

bind seg_page_xlate xlate_checker #(.PA_W(PA_W)) u_xlate_checker (.*);

// File: tb/tb_seg_page_xlate.sv
`timescale 1ns/1ps
module tb_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_seg = '0;
  logic [23:0] ld_base = '0;
  logic [8:0]  ld_bound = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int last_addr = 0;
  int tb_base  [16];
  int tb_bound [16];

  always #2.5 clk = ~clk;

  seg_page_xlate dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_seg(ld_seg), .ld_base(ld_base),
    .ld_bound(ld_bound), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] pte_of(input int a);
    int w;
    logic [11:0] fr;
    logic [2:0]  fl;
    w  = a >> 2;
    fr = 12'((w * 13 + 5) & 32'hfff);
    fl = 3'((w ^ (w >> 3)) & 7);
    return {12'b0, fr, 5'b0, fl};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= pte_of(int'(mem_rd_addr));
      last_addr   <= int'(mem_rd_addr);
      reads       <= reads + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic load(input int seg, input int base, input int bound);
    @(negedge clk);
    ld_en = 1'b1; ld_seg = 4'(seg); ld_base = 24'(base); ld_bound = 9'(bound);
    @(negedge clk);
    ld_en = 1'b0;
    tb_base[seg] = base; tb_bound[seg] = bound;
  endtask

  // expected: fault in [25:24], paddr in [23:0]
  function automatic int expect_of(input int seg, input int page, input int off, input bit wr);
    logic [31:0] p;
    if (page >= tb_bound[seg]) return 32'h0100_0000;
    p = pte_of(tb_base[seg] + page * 4);
    if (!p[2]) return 32'h0200_0000;
    if (wr ? !p[1] : !p[0]) return 32'h0300_0000;
    return int'({p[19:8], 12'(off)});
  endfunction

  task automatic issue(input int seg, input int page, input int off, input bit wr);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {4'(seg), 8'(page), 12'(off)};
    req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xlate(input int seg, input int page, input int off, input bit wr);
    int r0, e;
    bit inb;
    r0 = reads;
    e = expect_of(seg, page, off, wr);
    inb = page < tb_bound[seg];
    issue(seg, page, off, wr);
    while (!rsp_valid) @(negedge clk);
    if (!inb) check("R2 bounds fault code", int'(rsp_fault), 1);
    else if (e[25:24] == 2'd2) check("R3 not-present fault", int'(rsp_fault), 2);
    else if (e[25:24] == 2'd3) check("R4 protection fault", int'(rsp_fault), 3);
    else check("R5 no fault", int'(rsp_fault), 0);
    check("R5 physical address", int'(rsp_paddr), e & 32'h00ff_ffff);
    if (inb) begin
      check("R1 one memory read", reads - r0, 1);
      check("R1 entry address", last_addr, tb_base[seg] + page * 4);
    end else begin
      check("R2 no memory read", reads - r0, 0);
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int f0, a0;
    for (int s = 0; s < 16; s++) begin tb_base[s] = 0; tb_bound[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset req_ready", int'(req_ready), 1);
    check("R8 reset rsp_valid", int'(rsp_valid), 0);
    check("R8 reset mem_rd_en", int'(mem_rd_en), 0);
    xlate(5, 0, 12'h123, 1'b0);   // R8: limit 0 after reset gives bounds fault
    xlate(15, 255, 12'hfff, 1'b1);

    for (int s = 0; s < 16; s++)
      load(s, 24'h010000 + s * 24'h000400, (s == 15) ? 256 : s * 17);

    // full sweep: every segment, every page, both access kinds
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < 256; p++)
        for (int w = 0; w < 2; w++)
          xlate(s, p, (p * 37 + s * 5 + w * 2049) & 32'hfff, w[0]);

    // R7: load during a translation is ignored
    issue(3, 10, 12'h0aa, 1'b0);
    ld_en = 1'b1; ld_seg = 4'd3; ld_base = 24'h000000; ld_bound = 9'd0;
    @(negedge clk);
    @(negedge clk);
    ld_en = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(posedge clk);
    xlate(3, 10, 12'h0aa, 1'b0);
    check("R7 limit kept after ignored load", int'(rsp_fault == 2'b01), 0);
    // R7: load while idle takes effect
    load(3, 24'h020000, 0);
    xlate(3, 0, 12'h001, 1'b0);
    load(3, 24'h020000, 256);
    xlate(3, 200, 12'h321, 1'b1);

    // R6: response held under back-pressure
    rsp_ready = 1'b0;
    issue(9, 7, 12'h055, 1'b0);
    while (!rsp_valid) @(negedge clk);
    f0 = int'(rsp_fault); a0 = int'(rsp_paddr);
    repeat (3) @(negedge clk);
    check("R6 rsp_valid held", int'(rsp_valid), 1);
    check("R6 req_ready low while busy", int'(req_ready), 0);
    check("R6 fault stable", int'(rsp_fault), f0);
    check("R6 paddr stable", int'(rsp_paddr), a0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R6 rsp_valid drops after take", int'(rsp_valid), 0);
    check("R6 req_ready back", int'(req_ready), 1);
    summary();
  end
endmodule